// File: doc/BRIEF.md
# Noise Voice Generator

This block is the noise voice of a small programmable sound generator. A 15-bit shift register advances on a shift strobe that comes either from a divided internal tick or from the expiry pulse of tone channel 2. The lowest register bit gates a unipolar amplitude: when the bit is 1 the output carries a level set by a 4-bit attenuation, and when it is 0 the output is zero. A 3-bit control write chooses between periodic and white operation and picks the shift-rate source.

Every accepted control write puts the register back to its seed, even when the written value repeats the current setting. The seed has only the top bit set, so after a write the output stays low until that bit has shifted all the way down. Host code that keeps rewriting the control value therefore holds the voice silent. Mixing with the other voices is done elsewhere. No port carries a data stream: the control write is a single-cycle strobe with no back-pressure, and the amplitude is a level that is valid on every cycle.

Top module: `noise_chan`

## Requirements
- R1: After reset the output is 0, the mode is periodic, the rate code is 0, and the register holds the seed (only bit 14 set). With no write, the first high output comes after exactly 14 shifts.
- R2: Rate codes 0, 1 and 2 make one shift per 32, 64 and 128 cycles with `tick_en` high. The tick count restarts from zero on every control write.
- R3: With rate code 3, one shift happens on each cycle with `tone2_pulse` high, and `tick_en` has no effect.
- R4: In periodic mode (control bit 2 = 0), the bit leaving bit 0 re-enters at bit 14. After a write the output is high after shift 14 and again after shift 29, and low after every other shift in between.
- R5: In white mode (control bit 2 = 1), the bit entering at bit 14 is bit 0 XOR bit 1. The output equals bit 0 of that sequence, starting from the seed.
- R6: Each cycle with `ctl_we` high loads mode and rate from `ctl_val` and reseeds the register. This happens even when the value is unchanged. While writes repeat on every cycle, the output stays 0.
- R7: The output is 0 when bit 0 is 0. Otherwise it is (15 − `atten`) × 17, so `atten` = 0 gives 255 and `atten` = 15 gives 0.
- R8: A write in the same cycle as a shift strobe wins: the register is reseeded, and the new mode and rate apply from the next cycle.
- R9: In cycles with `tick_en` low, a rate code from 0 to 2 makes no progress toward the next shift, and the register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Internal tick enable, one tick per high cycle |
| tone2_pulse | input | 1 | Expiry pulse of tone channel 2 |
| ctl_we | input | 1 | Control write strobe |
| ctl_val | input | 3 | Bit 2: white (1) / periodic (0); bits 1:0: rate code |
| atten | input | 4 | Attenuation, 0 loudest, 15 silent |
| amp_o | output | 8 | Unipolar amplitude level |

## Verification
The assertions assume three things about the inputs. A rate change only ever arrives together with a reseed, since both come from the same write. `tone2_pulse` and `tick_en` are level inputs, sampled once per cycle. No control write arrives while reset is low. The stimulus drives all inputs on the falling edge and changes the rate only through the write strobe. The 3-bit control field then bounds the divider period, so the counter-range assertion cannot be hit by an out-of-range rate.

// File: rtl/noise_pkg.sv
package noise_pkg;

  typedef enum logic {
    MODE_PERIODIC = 1'b0,
    MODE_WHITE    = 1'b1
  } noise_mode_e;

  typedef struct packed {
    noise_mode_e mode;
    logic [1:0]  rate;
  } noise_ctl_t;

  localparam logic [1:0] RATE_TONE2 = 2'd3;
  localparam int         ATTEN_W    = 4;

endpackage

// File: rtl/noise_rate_div.sv
module noise_rate_div
  import noise_pkg::*;
#(
  parameter int DIV_BASE = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart_i,
  input  logic [1:0] rate_i,
  input  logic       tick_en_i,
  input  logic       tone2_pulse_i,
  output logic       shift_o
);

  localparam int MAX_PERIOD = DIV_BASE * 4;
  localparam int CNT_W      = $clog2(MAX_PERIOD) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period_m1;
  logic             use_tone2;
  logic             wrap;

  always_comb begin
    use_tone2 = (rate_i == RATE_TONE2);
    period_m1 = (CNT_W'(DIV_BASE) << rate_i) - CNT_W'(1);
    wrap      = tick_en_i && (cnt_q == period_m1);
    shift_o   = use_tone2 ? tone2_pulse_i : wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart_i || use_tone2) begin
      cnt_q <= '0;
    end else if (tick_en_i) begin
      cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
    end
  end

  // R2: the tick counter never passes the selected period
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !use_tone2 |-> (cnt_q <= period_m1));

  // R3: in tone-2 rate, only the expiry pulse produces a shift
  p_tone2_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (use_tone2 && !tone2_pulse_i) |-> !shift_o);

  // R9: no tick, no progress
  p_tick_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_tone2 && !tick_en_i && !restart_i) |=> $stable(cnt_q));

endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
  parameter int WIDTH = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seed_i,
  input  logic shift_i,
  input  logic white_i,
  output logic bit_o
);

  localparam logic [WIDTH-1:0] SEED = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] state_q;
  logic             fb;

  always_comb begin
    fb    = white_i ? (state_q[0] ^ state_q[1]) : state_q[0];
    bit_o = state_q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else if (seed_i) begin
      state_q <= SEED;
    end else if (shift_i) begin
      state_q <= {fb, state_q[WIDTH-1:1]};
    end
  end

  // R6 and R8: any write leaves the seed in the register, whatever the shift strobe does
  p_reseed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seed_i |=> (state_q == SEED));

  // R9: no strobe and no write keep the register unchanged
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_i && !shift_i) |=> $stable(state_q));

  // R4: a periodic shift only rotates, so the number of ones is preserved
  p_rot_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !seed_i && !white_i) |=>
      ($countones(state_q) == $countones($past(state_q))));

  // R5: the register never locks up at all zeros
  p_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

endmodule

// File: rtl/noise_amp.sv
module noise_amp
  import noise_pkg::*;
#(
  parameter int AMP_W = 8
) (
  input  logic [ATTEN_W-1:0] atten_i,
  input  logic               bit_i,
  output logic [AMP_W-1:0]   amp_o
);

  localparam int ATT_MAX  = (1 << ATTEN_W) - 1;
  localparam int LVL_STEP = ((1 << AMP_W) - 1) / ATT_MAX;

  logic [ATTEN_W-1:0] gain;
  logic [AMP_W-1:0]   level;

  always_comb begin
    gain  = ATTEN_W'(ATT_MAX) - atten_i;
    level = AMP_W'(gain) * AMP_W'(LVL_STEP);
    amp_o = bit_i ? level : '0;
  end

endmodule

// File: rtl/noise_chan.sv
module noise_chan
  import noise_pkg::*;
#(
  parameter int LFSR_W   = 15,
  parameter int DIV_BASE = 32,
  parameter int AMP_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             tone2_pulse,
  input  logic             ctl_we,
  input  logic [2:0]       ctl_val,
  input  logic [3:0]       atten,
  output logic [AMP_W-1:0] amp_o
);

  noise_ctl_t ctl_q;
  logic       shift;
  logic       lsb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '{mode: MODE_PERIODIC, rate: 2'd0};
    end else if (ctl_we) begin
      ctl_q <= noise_ctl_t'(ctl_val);
    end
  end

  noise_rate_div #(.DIV_BASE(DIV_BASE)) div_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart_i    (ctl_we),
    .rate_i       (ctl_q.rate),
    .tick_en_i    (tick_en),
    .tone2_pulse_i(tone2_pulse),
    .shift_o      (shift)
  );

  noise_lfsr #(.WIDTH(LFSR_W)) lfsr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .seed_i (ctl_we),
    .shift_i(shift),
    .white_i(ctl_q.mode == MODE_WHITE),
    .bit_o  (lsb)
  );

  noise_amp #(.AMP_W(AMP_W)) amp_i (
    .atten_i(atten),
    .bit_i  (lsb),
    .amp_o  (amp_o)
  );

  // R7: unipolar output, zero whenever the register bit is low
  p_zero_when_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lsb |-> (amp_o == '0));

  // R7: full scale at zero attenuation when the bit is high
  p_full_scale_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lsb && atten == 4'd0) |-> (amp_o == {AMP_W{1'b1}}));

  // R6: the cycle after a write the output is low
  p_write_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (amp_o == '0));

endmodule

// File: tb/noise_chan_tb_top.sv
module noise_chan_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       tone2_pulse = 1'b0;
  logic       ctl_we = 1'b0;
  logic [2:0] ctl_val = 3'd0;
  logic [3:0] atten = 4'd0;
  logic [7:0] amp_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  noise_chan dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tone2_pulse(tone2_pulse),
    .ctl_we(ctl_we), .ctl_val(ctl_val), .atten(atten), .amp_o(amp_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_val = v; tick_en = 1'b0; tone2_pulse = 1'b0;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
    end
    tick_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      tone2_pulse = 1'b1;
      @(negedge clk);
    end
    tone2_pulse = 1'b0;
  endtask

  // R1: reset state and first high after 14 shifts at rate 0
  task automatic t_reset();
    chk("R1 reset output", amp_o, 0);
    ticks(14 * 32 - 1);
    chk("R1 low after 13 shifts", amp_o, 0);
    ticks(1);
    chk("R1 high after 14 shifts", amp_o, 255);
  endtask

  // R4: periodic recurrence every 15 shifts
  task automatic t_periodic();
    wr(3'b000);
    ticks(14 * 32);
    chk("R4 high at shift 14", amp_o, 255);
    ticks(32);
    chk("R4 low at shift 15", amp_o, 0);
    ticks(13 * 32);
    chk("R4 low at shift 28", amp_o, 0);
    ticks(32);
    chk("R4 high at shift 29", amp_o, 255);
  endtask

  // R2: slower rate codes
  task automatic t_rates();
    wr(3'b001);
    ticks(14 * 64 - 1);
    chk("R2 rate1 low before shift 14", amp_o, 0);
    ticks(1);
    chk("R2 rate1 high at shift 14", amp_o, 255);
    wr(3'b010);
    ticks(14 * 128 - 1);
    chk("R2 rate2 low before shift 14", amp_o, 0);
    ticks(1);
    chk("R2 rate2 high at shift 14", amp_o, 255);
  endtask

  // R3: tone 2 pulse drives shifts, ticks ignored
  task automatic t_tone2();
    wr(3'b011);
    ticks(600);
    chk("R3 ticks ignored", amp_o, 0);
    pulses(13);
    chk("R3 low after 13 pulses", amp_o, 0);
    pulses(1);
    chk("R3 high after 14 pulses", amp_o, 255);
  endtask

  // R5: white sequence against a reference of the stated feedback
  task automatic t_white();
    int m = 32'h4000;
    int bad = 0;
    wr(3'b100);
    for (int s = 1; s <= 60; s++) begin
      ticks(32);
      m = (((m ^ (m >> 1)) & 1) << 14) | (m >> 1);
      if (amp_o !== ((m & 1) ? 8'd255 : 8'd0)) bad++;
    end
    chk("R5 white sequence mismatches", bad, 0);
  endtask

  // R6: rewrite of the same value reseeds; continuous writes silence
  task automatic t_rewrite();
    int bad = 0;
    wr(3'b000);
    ticks(14 * 32);
    chk("R6 high before rewrite", amp_o, 255);
    wr(3'b000);
    chk("R6 low after same-value rewrite", amp_o, 0);
    @(negedge clk);
    ctl_we = 1'b1; ctl_val = 3'b000; tick_en = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (amp_o !== 8'd0) bad++;
    end
    ctl_we = 1'b0; tick_en = 1'b0;
    chk("R6 continuous writes nonzero cycles", bad, 0);
    ticks(14 * 32);
    chk("R6 restart after writes stop", amp_o, 255);
  endtask

  // R8: write coincident with a shift strobe wins
  task automatic t_collide();
    wr(3'b000);
    ticks(31);
    @(negedge clk);
    ctl_we = 1'b1; ctl_val = 3'b100; tick_en = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0; tick_en = 1'b0;
    chk("R8 seeded on collision", amp_o, 0);
    ticks(14 * 32 - 1);
    chk("R8 count restarted", amp_o, 0);
    ticks(1);
    chk("R8 high at shift 14", amp_o, 255);
  endtask

  // R9: tick_en low freezes progress
  task automatic t_hold();
    wr(3'b000);
    ticks(14 * 32 - 1);
    repeat (200) @(negedge clk);
    chk("R9 no shift while idle", amp_o, 0);
    ticks(1);
    chk("R9 resumes on tick", amp_o, 255);
  endtask

  // R7: attenuation scaling while bit 0 is high and low
  task automatic t_atten();
    wr(3'b000);
    ticks(14 * 32);
    atten = 4'd5;  #1; chk("R7 atten 5", amp_o, 170);
    atten = 4'd15; #1; chk("R7 atten 15", amp_o, 0);
    atten = 4'd1;  #1; chk("R7 atten 1", amp_o, 238);
    ticks(32);
    atten = 4'd0;  #1; chk("R7 zero when bit low", amp_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_periodic();
    t_rates();
    t_tone2();
    t_white();
    t_rewrite();
    t_collide();
    t_hold();
    t_atten();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule